// File: doc/BRIEF.md
# Two-Stage Decimation Filter with Programmable Averager

This block turns the one-bit output of a delta-sigma modulator into signed 24-bit result words. The modulator delivers one bit every fourth clock, marked by a sample strobe. A fixed fifth-order sinc stage reduces the sample rate by 64. A first-order sinc stage then follows: a boxcar averager that sums N consecutive words from the first stage and releases one scaled result per group. N is chosen by writing an 8-bit rate code.

Each result is the averaged sum multiplied by a reciprocal constant for the chosen N, so full scale does not depend on N. Results outside the 24-bit range are clamped. Writing a new rate code restarts the decimation phase and the averager. Results are then withheld until the first stage has refilled. A single-cycle pulse marks every new result.

Top module: `ds_decimator`

## Requirements
- R1: While reset is low and after it is released, resultWord is 0 and resultValid is 0. Reset selects N = 1 (same as code 0xF0). The first result appears exactly 384 modulator samples after reset is released.
- R2: modBit = 1 enters the first stage as +1 and modBit = 0 as −1. The first stage is a fifth-order sinc decimator by 64. For a bit pattern whose period divides 64, its settled word equals 64^5 times the mean of the mapped inputs (pattern 1,0,1,1 gives 2^29). With N = 1 the result is that word shifted arithmetically right by 7 bits.
- R3: Rate codes select N as follows: 0x03→12000, 0x13→6000, 0x23→3000, 0x33→2000, 0x43→1200, 0x53→1000, 0x63→600, 0x72→500, 0x82→300, 0x92→60, 0xA1→30, 0xB0→15, 0xC0→8, 0xD0→4, 0xE0→2, 0xF0→1 (averaging bypassed). No other code is valid.
- R4: After any rate write, the first result appears exactly (5+N)·64 modulator samples later. Each later result follows the one before it after exactly N·64 samples.
- R5: Each result is floor(S·K / 2^31). S is the sum of N consecutive first-stage words, and K = round(2^24 / N).
- R6: A result above 0x7FFFFF is clamped to 0x7FFFFF. A result below −2^23 is clamped to 0x800000.
- R7: Writing a code not listed in R3 leaves N unchanged, but still restarts the filter as in R4.
- R8: resultValid is high for exactly one clock per result. resultWord changes only when resultValid is high and holds its value between pulses.
- R9: A rate write throws away any partly accumulated average. The first result after the write covers only words taken after the write.
- R10: modBit is ignored in every cycle where modStrobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modStrobe | input | 1 | Marks a valid modulator bit (once every four clocks) |
| modBit | input | 1 | Modulator output bit |
| rateCode | input | 8 | Rate code, taken when rateWrite is high |
| rateWrite | input | 1 | Write strobe for rateCode |
| resultWord | output | 24 | Signed filtered result |
| resultValid | output | 1 | One-cycle pulse with each new result |

## Verification
If the decimation phase or the refill counter is wrong, the first result arrives a multiple of 64 samples too early or too late. Counting strobes from a write to the first pulse shows this on the first result. If the averager count or the accumulator is wrong, the result spacing or the value is off from the second result onward. A stale sum left over from before a write shows up in the very first value after that write. Errors in the integrators, the comb stages or the reciprocal appear as a wrong settled value for periodic bit patterns of known mean, one group after refill.

// File: rtl/ds_decim_pkg.sv
package ds_decim_pkg;

  // Largest averaging count (12000) fits in 14 bits.
  localparam int AVG_CNT_W  = 14;
  // Fraction bits of the reciprocal constant.
  localparam int RECIP_FRAC = 24;
  // One spare bit so the value stays non-negative when read as signed.
  localparam int RECIP_W    = RECIP_FRAC + 2;

  typedef struct packed {
    logic sampleEn;   // modulator bit accepted this cycle
    logic decimEn;    // first stage emits a word this cycle
    logic keepEn;     // registered first-stage word goes into the averager
    logic keepLast;   // that word closes the current group
    logic clearAll;   // rate write: flush the averager
  } ctrl_strobes_t;

  typedef struct packed {
    logic                 hit;
    logic [AVG_CNT_W-1:0] numAve;
    logic [RECIP_W-1:0]   recip;
  } rate_entry_t;

  // Entry with round(2^RECIP_FRAC / n), folded to a constant per call site.
  function automatic rate_entry_t mkEntry(input int n);
    rate_entry_t e;
    logic [63:0] q;
    q = ((64'd1 << (RECIP_FRAC + 1)) / 64'(n) + 64'd1) >> 1;
    e.hit    = 1'b1;
    e.numAve = AVG_CNT_W'(n);
    e.recip  = RECIP_W'(q);
    return e;
  endfunction

  function automatic rate_entry_t decodeRate(input logic [7:0] code);
    rate_entry_t e;
    case (code)
      8'h03:   e = mkEntry(12000);
      8'h13:   e = mkEntry(6000);
      8'h23:   e = mkEntry(3000);
      8'h33:   e = mkEntry(2000);
      8'h43:   e = mkEntry(1200);
      8'h53:   e = mkEntry(1000);
      8'h63:   e = mkEntry(600);
      8'h72:   e = mkEntry(500);
      8'h82:   e = mkEntry(300);
      8'h92:   e = mkEntry(60);
      8'hA1:   e = mkEntry(30);
      8'hB0:   e = mkEntry(15);
      8'hC0:   e = mkEntry(8);
      8'hD0:   e = mkEntry(4);
      8'hE0:   e = mkEntry(2);
      8'hF0:   e = mkEntry(1);
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/ds_decim_ctrl.sv
module ds_decim_ctrl
  import ds_decim_pkg::*;
#(
  parameter int CIC_ORDER  = 5,
  parameter int DECIM_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modStrobe,
  input  logic [7:0]         rateCode,
  input  logic               rateWrite,
  output ctrl_strobes_t      strobes,
  output logic [RECIP_W-1:0] recip
);

  localparam int DISC_W = $clog2(CIC_ORDER + 1);
  localparam logic [DISC_W-1:0] REFILL = DISC_W'(CIC_ORDER);
  localparam rate_entry_t RESET_ENTRY = decodeRate(8'hF0);

  rate_entry_t           newEntry;
  logic [AVG_CNT_W-1:0]  numAveQ;
  logic [RECIP_W-1:0]    recipQ;
  logic [DECIM_LOG2-1:0] phaseQ;
  logic                  decimQ;
  logic [DISC_W-1:0]     discardQ;
  logic [AVG_CNT_W-1:0]  avgCntQ;
  logic                  keepQ;
  logic                  lastQ;
  logic                  groupEnd;

  assign newEntry = decodeRate(rateCode);
  assign groupEnd = (avgCntQ == numAveQ - AVG_CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numAveQ  <= RESET_ENTRY.numAve;
      recipQ   <= RESET_ENTRY.recip;
      phaseQ   <= '0;
      decimQ   <= 1'b0;
      discardQ <= REFILL;
      avgCntQ  <= '0;
      keepQ    <= 1'b0;
      lastQ    <= 1'b0;
    end else begin
      decimQ <= 1'b0;
      keepQ  <= 1'b0;
      lastQ  <= 1'b0;
      if (rateWrite) begin
        if (newEntry.hit) begin
          numAveQ <= newEntry.numAve;
          recipQ  <= newEntry.recip;
        end
        phaseQ   <= '0;
        discardQ <= REFILL;
        avgCntQ  <= '0;
      end else begin
        if (modStrobe) begin
          phaseQ <= phaseQ + DECIM_LOG2'(1);
          decimQ <= &phaseQ;
        end
        if (decimQ) begin
          if (discardQ != '0) begin
            discardQ <= discardQ - DISC_W'(1);
          end else begin
            keepQ   <= 1'b1;
            lastQ   <= groupEnd;
            avgCntQ <= groupEnd ? '0 : avgCntQ + AVG_CNT_W'(1);
          end
        end
      end
    end
  end

  assign strobes.sampleEn = modStrobe;
  assign strobes.decimEn  = decimQ;
  assign strobes.keepEn   = keepQ;
  assign strobes.keepLast = lastQ;
  assign strobes.clearAll = rateWrite;
  assign recip            = recipQ;

endmodule

// File: rtl/ds_decim_datapath.sv
module ds_decim_datapath
  import ds_decim_pkg::*;
#(
  parameter int CIC_ORDER  = 5,
  parameter int DECIM_LOG2 = 6,
  parameter int OUT_W      = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strobes,
  input  logic               modBit,
  input  logic [RECIP_W-1:0] recip,
  output logic [OUT_W-1:0]   resultWord,
  output logic               resultValid
);

  localparam int GROWTH      = CIC_ORDER * DECIM_LOG2;
  localparam int CIC_W       = GROWTH + 2;
  localparam int ACC_W       = CIC_W + AVG_CNT_W;
  localparam int PROD_W      = ACC_W + RECIP_W;
  localparam int SCALE_SHIFT = RECIP_FRAC + GROWTH - (OUT_W - 1);

  // ---------------- integrators (run at the sample rate) ----------------
  logic signed [CIC_W-1:0] stepIn;
  logic signed [CIC_W-1:0] integQ [CIC_ORDER];

  assign stepIn = modBit ? CIC_W'(1) : '1;

  for (genvar gi = 0; gi < CIC_ORDER; gi++) begin : g_integ
    logic signed [CIC_W-1:0] feed;
    if (gi == 0) begin : g_first
      assign feed = stepIn;
    end else begin : g_chain
      assign feed = integQ[gi-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                integQ[gi] <= '0;
      else if (strobes.sampleEn) integQ[gi] <= integQ[gi] + feed;
    end
  end

  // ---------------- combs (run at the decimated rate) ----------------
  logic signed [CIC_W-1:0] combIn  [CIC_ORDER+1];
  logic signed [CIC_W-1:0] combDlyQ [CIC_ORDER];
  logic signed [CIC_W-1:0] cicQ;

  assign combIn[0] = integQ[CIC_ORDER-1];

  for (genvar gc = 0; gc < CIC_ORDER; gc++) begin : g_comb
    assign combIn[gc+1] = combIn[gc] - combDlyQ[gc];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               combDlyQ[gc] <= '0;
      else if (strobes.decimEn) combDlyQ[gc] <= combIn[gc];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cicQ <= '0;
    else if (strobes.decimEn) cicQ <= combIn[CIC_ORDER];
  end

  // ---------------- averager and output scaling ----------------
  logic signed [ACC_W-1:0]  accQ;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [PROD_W-1:0] accWide;
  logic signed [PROD_W-1:0] recipWide;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] shifted;
  logic [PROD_W-OUT_W:0]    headBits;
  logic [OUT_W-1:0]         satWord;
  logic [OUT_W-1:0]         resultQ;
  logic                     validQ;

  assign accNext   = accQ + {{AVG_CNT_W{cicQ[CIC_W-1]}}, cicQ};
  assign accWide   = {{RECIP_W{accNext[ACC_W-1]}}, accNext};
  assign recipWide = {{ACC_W{1'b0}}, recip};
  assign product   = accWide * recipWide;
  assign shifted   = product >>> SCALE_SHIFT;
  assign headBits  = shifted[PROD_W-1:OUT_W-1];

  always_comb begin
    if ((&headBits) || !(|headBits)) begin
      satWord = shifted[OUT_W-1:0];
    end else if (shifted[PROD_W-1]) begin
      satWord = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      satWord = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (strobes.clearAll) begin
        accQ <= '0;
      end else if (strobes.keepEn) begin
        if (strobes.keepLast) begin
          accQ    <= '0;
          resultQ <= satWord;
          validQ  <= 1'b1;
        end else begin
          accQ <= accNext;
        end
      end
    end
  end

  assign resultWord  = resultQ;
  assign resultValid = validQ;

endmodule

// File: rtl/ds_decimator.sv
module ds_decimator
  import ds_decim_pkg::*;
#(
  parameter int CIC_ORDER  = 5,
  parameter int DECIM_LOG2 = 6,
  parameter int OUT_W      = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modStrobe,
  input  logic             modBit,
  input  logic [7:0]       rateCode,
  input  logic             rateWrite,
  output logic [OUT_W-1:0] resultWord,
  output logic             resultValid
);

  ctrl_strobes_t      strobes;
  logic [RECIP_W-1:0] recip;

  ds_decim_ctrl #(
    .CIC_ORDER (CIC_ORDER),
    .DECIM_LOG2(DECIM_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modStrobe(modStrobe),
    .rateCode (rateCode),
    .rateWrite(rateWrite),
    .strobes  (strobes),
    .recip    (recip)
  );

  ds_decim_datapath #(
    .CIC_ORDER (CIC_ORDER),
    .DECIM_LOG2(DECIM_LOG2),
    .OUT_W     (OUT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modBit     (modBit),
    .recip      (recip),
    .resultWord (resultWord),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/ds_decimator_chk.sv
module ds_decimator_chk #(
  parameter int DECIM_LOG2 = 6,
  parameter int OUT_W      = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             modStrobe,
  input logic             rateWrite,
  input logic [OUT_W-1:0] resultWord,
  input logic             resultValid
);

  localparam int CNT_W = DECIM_LOG2 + 4;
  localparam logic [CNT_W-1:0] MIN_GAP = CNT_W'(1 << DECIM_LOG2);

  // Samples seen since the last result or rate write, saturating.
  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (rateWrite) begin
      gapCnt <= '0;
    end else if (resultValid) begin
      gapCnt <= modStrobe ? CNT_W'(1) : '0;
    end else if (modStrobe && !(&gapCnt)) begin
      gapCnt <= gapCnt + CNT_W'(1);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (resultWord == '0 && !resultValid));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultWord));

  assert_no_result_after_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    rateWrite |=> !resultValid);

  assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> gapCnt >= MIN_GAP);

endmodule

bind ds_decimator ds_decimator_chk #(
  .DECIM_LOG2(DECIM_LOG2),
  .OUT_W     (OUT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modStrobe  (modStrobe),
  .rateWrite  (rateWrite),
  .resultWord (resultWord),
  .resultValid(resultValid)
);

// File: tb/ds_decimator_tb.sv
`timescale 1ns/1ps
module ds_decimator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  // Table: rate code, repeating 4-bit modulator pattern, expected N.
  localparam logic [7:0] VEC_CODE [NVEC] = '{8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA1, 8'h92};
  localparam logic [3:0] VEC_PAT  [NVEC] = '{4'b1011, 4'b0000, 4'b1111, 4'b1100, 4'b0111, 4'b0001, 4'b1010};
  localparam int         VEC_N    [NVEC] = '{1, 2, 4, 8, 15, 30, 60};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modStrobe;
  logic        modBit;
  logic [7:0]  rateCode;
  logic        rateWrite;
  logic [23:0] resultWord;
  logic        resultValid;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [3:0] curPat = 4'b1011;
  int         sampleCount = 0;
  bit         writeReq = 1'b0;
  logic [7:0] writeCode = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds_decimator u_dut (
    .clk(clk), .rstN(rstN), .modStrobe(modStrobe), .modBit(modBit),
    .rateCode(rateCode), .rateWrite(rateWrite),
    .resultWord(resultWord), .resultValid(resultValid)
  );

  // Input driver: one strobe every 4 clocks, rate writes two clocks after
  // a strobe, and modBit toggled in non-strobe cycles (must be ignored, R10).
  initial begin
    int drvPhase;
    int patIdx;
    drvPhase = 0;
    patIdx = 0;
    modStrobe = 1'b0;
    modBit = 1'b0;
    rateCode = 8'h00;
    rateWrite = 1'b0;
    forever begin
      @(negedge clk);
      modStrobe = 1'b0;
      rateWrite = 1'b0;
      if (!rstN) begin
        drvPhase = 0;
        sampleCount = 0;
      end else begin
        if (drvPhase == 0) begin
          modStrobe = 1'b1;
          modBit = curPat[3 - patIdx];
          patIdx = (patIdx + 1) % 4;
          sampleCount++;
        end else begin
          modBit = ~modBit;
          if (drvPhase == 2 && writeReq) begin
            rateWrite = 1'b1;
            rateCode = writeCode;
            writeReq = 1'b0;
            sampleCount = 0;
          end
        end
        drvPhase = (drvPhase + 1) % 4;
      end
    end
  end

  function automatic logic [23:0] expectWord(input int n, input logic [3:0] pat);
    longint cic, sum, recip, prod, sh;
    cic = longint'($countones(pat) - 2) * (longint'(1) << 29);
    sum = cic * n;
    recip = (((longint'(1) << 25) / n) + 1) / 2;
    prod = sum * recip;
    sh = prod >>> 31;
    if (sh > 64'sd8388607) sh = 64'sd8388607;
    if (sh < -64'sd8388608) sh = -64'sd8388608;
    return sh[23:0];
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] code);
    writeCode = code;
    writeReq = 1'b1;
    wait (writeReq == 1'b0);
  endtask

  task automatic waitValid(input int limitClk, output bit got, output int cnt, output logic [23:0] val);
    got = 1'b0;
    cnt = 0;
    val = '0;
    for (int i = 0; i < limitClk; i++) begin
      @(posedge clk);
      #2;
      if (resultValid) begin
        got = 1'b1;
        cnt = sampleCount;
        val = resultWord;
        return;
      end
    end
  endtask

  // One cycle after a pulse: pulse gone, word held (R8).
  task automatic checkPulse(input logic [23:0] val);
    @(posedge clk);
    #2;
    check("R8", "pulse width", longint'(resultValid), 0);
    check("R8", "word held", longint'(resultWord), longint'(val));
  endtask

  initial begin
    bit got;
    int cnt;
    int cnt2;
    logic [23:0] val;

    // ---- R1: reset state and first result after reset ----
    repeat (3) @(posedge clk);
    #2;
    check("R1", "word in reset", longint'(resultWord), 0);
    check("R1", "valid in reset", longint'(resultValid), 0);
    @(posedge clk);
    #2;
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check("R1", "word after reset", longint'(resultWord), 0);
    check("R1", "valid after reset", longint'(resultValid), 0);
    waitValid(400 * 4, got, cnt, val);
    check("R1", "first result seen", longint'(got), 1);
    check("R1", "first result latency", cnt, 384);
    check("R1/R2", "bypass value", longint'(val), 24'h400000);
    checkPulse(val);

    // ---- table walk: R2 R3 R4 R5 R6 R10 ----
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] expV;
      int n;
      n = VEC_N[v];
      expV = expectWord(n, VEC_PAT[v]);
      curPat = VEC_PAT[v];
      doWrite(VEC_CODE[v]);
      waitValid((5 + n) * 64 * 4 + 64, got, cnt, val);
      check("R3", $sformatf("code %0h result seen", VEC_CODE[v]), longint'(got), 1);
      check("R4", $sformatf("code %0h first latency", VEC_CODE[v]), cnt, (5 + n) * 64);
      check("R5/R6/R10", $sformatf("code %0h first value", VEC_CODE[v]), longint'(val), longint'(expV));
      checkPulse(val);
      waitValid(n * 64 * 4 + 64, got, cnt2, val);
      check("R4", $sformatf("code %0h spacing", VEC_CODE[v]), cnt2 - cnt, n * 64);
      check("R2/R5", $sformatf("code %0h second value", VEC_CODE[v]), longint'(val), longint'(expV));
    end

    // ---- R6: negative clamp in bypass, pattern all zero ----
    curPat = 4'b0000;
    doWrite(8'hF0);
    waitValid(6 * 64 * 4 + 64, got, cnt, val);
    check("R6", "negative full scale", longint'(val), 24'h800000);
    curPat = 4'b1111;
    doWrite(8'hF0);
    waitValid(6 * 64 * 4 + 64, got, cnt, val);
    check("R6", "positive clamp", longint'(val), 24'h7FFFFF);

    // ---- R9: write mid-group flushes the partial sum ----
    curPat = 4'b0000;
    doWrite(8'hC0);
    waitValid(13 * 64 * 4 + 64, got, cnt, val);
    check("R9", "setup result", longint'(val), longint'(expectWord(8, 4'b0000)));
    while (sampleCount < cnt + 200) @(posedge clk);
    #2;
    curPat = 4'b1111;
    doWrite(8'hC0);
    waitValid(13 * 64 * 4 + 64, got, cnt, val);
    check("R9", "latency after flush", cnt, 13 * 64);
    check("R9", "value after flush", longint'(val), 24'h7FFFFF);

    // ---- R7: invalid code keeps N, still restarts ----
    curPat = 4'b1011;
    doWrite(8'hE0);
    waitValid(7 * 64 * 4 + 64, got, cnt, val);
    doWrite(8'h55);
    waitValid(7 * 64 * 4 + 64, got, cnt, val);
    check("R7", "latency after invalid code", cnt, 7 * 64);
    check("R7", "value after invalid code", longint'(val), longint'(expectWord(2, 4'b1011)));
    waitValid(2 * 64 * 4 + 64, got, cnt2, val);
    check("R7", "spacing after invalid code", cnt2 - cnt, 128);

    // ---- R3: slowest code gives no result within 2000 samples ----
    doWrite(8'h03);
    waitValid(2000 * 4, got, cnt, val);
    check("R3", "no early result for code 03", longint'(got), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule